// File: doc/BRIEF.md
# Command-List I2C Master Sequencer

This block is the control half of an I2C master. Software fills a sixteen-slot command list through a small register port. Each slot holds a command byte that can ask for a START, a STOP, a byte transmit or a byte receive, with an option to answer a received byte with NACK. A transmit command takes the slot right after it as the byte to send. Writing the launch register makes the sequencer walk the list by itself. For each command it hands one byte-level request to a separate bit engine that drives SCL and SDA. It then waits for that engine's completion pulse and moves on.

Received bytes are packed four to a word into a small data buffer. The sequencer stops after the last non-empty entry or after entry 15, whichever comes first. It then raises a done flag. A slave that does not acknowledge a transmitted byte raises an error flag and a NACK flag and ends the list early. Both flags can drive the interrupt line, and software clears them by writing 1 to them. A self-clearing soft reset and a halt command both return the sequencer to idle and pulse an abort line to the bit engine, which releases the bus.

Top module: `i2cseq_top`

## Requirements
- R1: After reset the status register (0x0C) reads 0, `irq` is 0 and `engReq` is 0.
- R2: In a command byte, bit 7 requests START, bit 6 STOP, bit 5 READ, bit 4 WRITE and bit 3 NACK-on-receive. While a command is being executed, `engReq` is high and `engStart`, `engStop`, `engRead`, `engWrite` and `engNack` carry those bits. Bits 2:0 are ignored.
- R3: A WRITE command sends the byte held in the following slot on `engTxByte`. The command index then advances by two. Any other command advances it by one.
- R4: The n-th byte received since launch is stored in the data word at 0x80 + 4*(n/4), in byte lane n mod 4 (lane 0 = bits 7:0).
- R5: Execution ends at the first entry whose bits 7:4 are all zero, or after entry 15. Done (status bit 8) is set only after the last request has completed. Busy (status bit 0) is high from launch until then.
- R6: If `engAck` is low when a WRITE request completes, error (bit 9) and NACK (bit 2) are set, no further request is made and done stays clear.
- R7: `irq` and status bit 4 equal (done AND control bit 11) OR (error AND control bit 12).
- R8: Writing 1 to status bit 8 clears done, and writing 1 to bit 9 clears error. Other status bits are not affected by those writes.
- R9: Writing 1 to bit 0 of the launch register (0x1C) starts the list at entry 0 and clears done, error, NACK and stop-issued. This happens only when control bits 1 (core enable) and 2 (master mode) are both set. Otherwise it is ignored.
- R10: Writing 0 to bit 0 of the launch register stops the sequencer. Busy clears, done is not set and `engAbort` pulses.
- R11: Writing 1 to control bit 0 starts a soft reset. The bit reads 1 for one cycle, then clears by itself. The reset clears all status flags and the command index, and pulses `engAbort`.
- R12: Status bit 6 is set when a command carrying STOP completes.
- R13: Status bits 20:16 show the current command index. Bit 1 is high while a request is outstanding to the bit engine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data (combinational on regAddr) |
| engReq | output | 1 | Byte request to the bit engine, held until engDone |
| engStart | output | 1 | Request begins with a START |
| engStop | output | 1 | Request ends with a STOP |
| engRead | output | 1 | Request receives a byte |
| engWrite | output | 1 | Request transmits a byte |
| engNack | output | 1 | Answer the received byte with NACK |
| engTxByte | output | 8 | Byte to transmit |
| engDone | input | 1 | One-cycle completion pulse from the bit engine |
| engAck | input | 1 | Slave acknowledged the transmitted byte |
| engRxByte | input | 8 | Received byte, valid with engDone |
| engAbort | output | 1 | Pulse telling the bit engine to stop and release the bus |
| irq | output | 1 | Interrupt request |

## Verification
The list engine is exercised with four kinds of list. A pure transmit list with a STOP on the last byte checks that write slots are skipped by two. A mixed list of an address write followed by reads that ends in a NACK-and-STOP read checks the byte-lane packing and the transition from single-step to double-step indexing. A full sixteen-read list with no terminator checks that the buffer-end rule stops execution, and an address that is not acknowledged checks the early abort. Around these, a disabled-core launch, a halt in the middle of a request and a soft reset show that control writes stop the engine without setting done. Sweeping the two interrupt enables separates the flag from the interrupt line.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  // Command byte bit positions (decoded by the sequencer and the bit engine)
  localparam int CB_START = 7;
  localparam int CB_STOP  = 6;
  localparam int CB_READ  = 5;
  localparam int CB_WRITE = 4;
  localparam int CB_NACK  = 3;

  // Register offsets
  localparam int OFF_STATUS = 'h0C;
  localparam int OFF_CTRL   = 'h10;
  localparam int OFF_LAUNCH = 'h1C;
  localparam int OFF_CMD    = 'h30;
  localparam int OFF_DATA   = 'h80;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearRun;
    logic setDone;
    logic setErr;
    logic setNack;
    logic setStop;
    logic storeRx;
  } seqStrobe_t;

endpackage

// File: rtl/i2cseq_regs.sv
module i2cseq_regs
  import i2cseq_pkg::*;
#(
  parameter int CMD_DEPTH  = 16,
  parameter int DATA_DEPTH = 16,
  parameter int ADDR_W     = 8,
  localparam int IDX_W      = $clog2(CMD_DEPTH),
  localparam int PTR_W      = IDX_W + 1,
  localparam int CNT_W      = $clog2(DATA_DEPTH) + 1,
  localparam int DATA_WORDS = (DATA_DEPTH + 3) / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  input  seqStrobe_t        strobe,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              busy,
  input  logic              tip,
  input  logic [7:0]        rxByte,
  output logic              launch,
  output logic              haltReq,
  output logic              softReset,
  output logic              runEnable,
  output logic [7:0]        curCmd,
  output logic [7:0]        nextByte,
  output logic              doneFlag,
  output logic              errFlag,
  output logic              irq
);

  logic [7:0] cmdBuf  [CMD_DEPTH];
  logic [7:0] dataBuf [DATA_DEPTH];
  logic [31:0] dataWord [DATA_WORDS];
  logic [CMD_DEPTH-1:0] cmdHit;
  logic [CNT_W-1:0] rdCount;
  logic nackFlag, stopFlag;
  logic rstPend, coreEn, masterEn, doneIrqEn, errIrqEn;
  logic wrStatus, wrCtrl, wrLaunch;
  logic [PTR_W-1:0] ptrInc;

  assign wrStatus = regWr && (regAddr == ADDR_W'(OFF_STATUS));
  assign wrCtrl   = regWr && (regAddr == ADDR_W'(OFF_CTRL));
  assign wrLaunch = regWr && (regAddr == ADDR_W'(OFF_LAUNCH));

  assign launch    = wrLaunch &&  regWData[0];
  assign haltReq   = wrLaunch && !regWData[0];
  assign softReset = rstPend;
  assign runEnable = coreEn && masterEn;

  // Per-slot write decode
  for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_cmdHit
    assign cmdHit[g] = regWr && (regAddr == ADDR_W'(OFF_CMD + 4 * g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CMD_DEPTH; i++) cmdBuf[i] <= '0;
    end else begin
      for (int i = 0; i < CMD_DEPTH; i++)
        if (cmdHit[i]) cmdBuf[i] <= regWData[7:0];
    end
  end

  // Command fetch ports
  assign ptrInc = ptr + 1'b1;
  always_comb begin
    curCmd   = '0;
    nextByte = '0;
    if (ptr < PTR_W'(CMD_DEPTH))    curCmd   = cmdBuf[ptr[IDX_W-1:0]];
    if (ptrInc < PTR_W'(CMD_DEPTH)) nextByte = cmdBuf[ptrInc[IDX_W-1:0]];
  end

  // Received-byte buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCount <= '0;
      for (int i = 0; i < DATA_DEPTH; i++) dataBuf[i] <= '0;
    end else if (softReset || strobe.clearRun) begin
      rdCount <= '0;
    end else if (strobe.storeRx && (rdCount < CNT_W'(DATA_DEPTH))) begin
      for (int i = 0; i < DATA_DEPTH; i++)
        if (rdCount == CNT_W'(i)) dataBuf[i] <= rxByte;
      rdCount <= rdCount + 1'b1;
    end
  end

  // Byte i lands in lane i mod 4 of word i/4
  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_dataWord
    for (genvar l = 0; l < 4; l++) begin : g_lane
      if (4 * w + l < DATA_DEPTH) begin : g_used
        assign dataWord[w][8*l +: 8] = dataBuf[4*w+l];
      end else begin : g_pad
        assign dataWord[w][8*l +: 8] = 8'h00;
      end
    end
  end

  // Control register with self-clearing soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPend   <= 1'b0;
      coreEn    <= 1'b0;
      masterEn  <= 1'b0;
      doneIrqEn <= 1'b0;
      errIrqEn  <= 1'b0;
    end else begin
      if (rstPend)     rstPend <= 1'b0;
      else if (wrCtrl) rstPend <= regWData[0];
      if (wrCtrl) begin
        coreEn    <= regWData[1];
        masterEn  <= regWData[2];
        doneIrqEn <= regWData[11];
        errIrqEn  <= regWData[12];
      end
    end
  end

  // Status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      nackFlag <= 1'b0;
      stopFlag <= 1'b0;
    end else if (softReset || strobe.clearRun) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      nackFlag <= 1'b0;
      stopFlag <= 1'b0;
    end else begin
      if (strobe.setDone)                doneFlag <= 1'b1;
      else if (wrStatus && regWData[8])  doneFlag <= 1'b0;
      if (strobe.setErr)                 errFlag  <= 1'b1;
      else if (wrStatus && regWData[9])  errFlag  <= 1'b0;
      if (strobe.setNack)                nackFlag <= 1'b1;
      if (strobe.setStop)                stopFlag <= 1'b1;
    end
  end

  assign irq = (doneFlag && doneIrqEn) || (errFlag && errIrqEn);

  // Read mux
  always_comb begin
    regRData = '0;
    if (regAddr == ADDR_W'(OFF_STATUS)) begin
      regRData[0]              = busy;
      regRData[1]              = tip;
      regRData[2]              = nackFlag;
      regRData[4]              = irq;
      regRData[6]              = stopFlag;
      regRData[8]              = doneFlag;
      regRData[9]              = errFlag;
      regRData[16 +: PTR_W]    = ptr;
    end
    if (regAddr == ADDR_W'(OFF_CTRL)) begin
      regRData[0]  = rstPend;
      regRData[1]  = coreEn;
      regRData[2]  = masterEn;
      regRData[11] = doneIrqEn;
      regRData[12] = errIrqEn;
    end
    for (int i = 0; i < CMD_DEPTH; i++)
      if (regAddr == ADDR_W'(OFF_CMD + 4 * i)) regRData = {24'h0, cmdBuf[i]};
    for (int w = 0; w < DATA_WORDS; w++)
      if (regAddr == ADDR_W'(OFF_DATA + 4 * w)) regRData = dataWord[w];
  end

  logic unusedWData;
  assign unusedWData = ^{regWData[31:13], regWData[10], regWData[7:3]};

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  localparam int IDX_W    = $clog2(CMD_DEPTH),
  localparam int PTR_W    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic             haltReq,
  input  logic             softReset,
  input  logic             runEnable,
  input  logic [7:0]       curCmd,
  input  logic [7:0]       nextByte,
  input  logic             engDone,
  input  logic             engAck,
  output seqStrobe_t       strobe,
  output logic [PTR_W-1:0] ptr,
  output logic             busy,
  output logic             engReq,
  output logic             engStart,
  output logic             engStop,
  output logic             engRead,
  output logic             engWrite,
  output logic             engNack,
  output logic [7:0]       engTxByte,
  output logic             engAbort
);

  seqState_t state, stateNext;
  logic [PTR_W-1:0] ptrNext;
  logic [7:0] latCmd, latTx;
  logic active, listEnd, accept, nakErr, doLatch;

  assign active  = !softReset && !haltReq;
  assign listEnd = (ptr >= PTR_W'(CMD_DEPTH)) || (curCmd[7:4] == 4'h0);
  assign accept  = (state == ST_WAIT) && engDone && active;
  assign nakErr  = accept && latCmd[CB_WRITE] && !engAck;

  always_comb begin
    stateNext = state;
    ptrNext   = ptr;
    doLatch   = 1'b0;
    strobe    = '0;
    if (softReset) begin
      stateNext = ST_IDLE;
      ptrNext   = '0;
    end else if (haltReq) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch && runEnable) begin
            stateNext       = ST_FETCH;
            ptrNext         = '0;
            strobe.clearRun = 1'b1;
          end
        end
        ST_FETCH: begin
          if (listEnd) begin
            stateNext      = ST_IDLE;
            strobe.setDone = 1'b1;
          end else begin
            stateNext = ST_WAIT;
            doLatch   = 1'b1;
          end
        end
        ST_WAIT: begin
          if (nakErr) begin
            stateNext      = ST_IDLE;
            strobe.setErr  = 1'b1;
            strobe.setNack = 1'b1;
          end else if (accept) begin
            stateNext      = ST_FETCH;
            strobe.storeRx = latCmd[CB_READ];
            strobe.setStop = latCmd[CB_STOP];
            ptrNext        = ptr + (latCmd[CB_WRITE] ? PTR_W'(2) : PTR_W'(1));
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      latCmd <= '0;
      latTx  <= '0;
    end else begin
      state <= stateNext;
      ptr   <= ptrNext;
      if (doLatch) begin
        latCmd <= curCmd;
        latTx  <= nextByte;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign engReq    = (state == ST_WAIT);
  assign engStart  = latCmd[CB_START];
  assign engStop   = latCmd[CB_STOP];
  assign engRead   = latCmd[CB_READ];
  assign engWrite  = latCmd[CB_WRITE];
  assign engNack   = latCmd[CB_NACK];
  assign engTxByte = latTx;
  assign engAbort  = softReset || haltReq;

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int CMD_DEPTH  = 16,
  parameter int DATA_DEPTH = 16,
  parameter int ADDR_W     = 8,
  localparam int PTR_W     = $clog2(CMD_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  output logic              engReq,
  output logic              engStart,
  output logic              engStop,
  output logic              engRead,
  output logic              engWrite,
  output logic              engNack,
  output logic [7:0]        engTxByte,
  input  logic              engDone,
  input  logic              engAck,
  input  logic [7:0]        engRxByte,
  output logic              engAbort,
  output logic              irq
);

  seqStrobe_t strobe;
  logic [PTR_W-1:0] ptr;
  logic busy, launch, haltReq, softReset, runEnable;
  logic doneFlag, errFlag;
  logic [7:0] curCmd, nextByte;

  i2cseq_regs #(
    .CMD_DEPTH(CMD_DEPTH), .DATA_DEPTH(DATA_DEPTH), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .strobe(strobe), .ptr(ptr),
    .busy(busy), .tip(engReq), .rxByte(engRxByte), .launch(launch),
    .haltReq(haltReq), .softReset(softReset), .runEnable(runEnable),
    .curCmd(curCmd), .nextByte(nextByte), .doneFlag(doneFlag),
    .errFlag(errFlag), .irq(irq)
  );

  i2cseq_ctrl #(.CMD_DEPTH(CMD_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .launch(launch), .haltReq(haltReq),
    .softReset(softReset), .runEnable(runEnable), .curCmd(curCmd),
    .nextByte(nextByte), .engDone(engDone), .engAck(engAck),
    .strobe(strobe), .ptr(ptr), .busy(busy), .engReq(engReq),
    .engStart(engStart), .engStop(engStop), .engRead(engRead),
    .engWrite(engWrite), .engNack(engNack), .engTxByte(engTxByte),
    .engAbort(engAbort)
  );

endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
  parameter int CMD_DEPTH = 16,
  localparam int PTR_W    = $clog2(CMD_DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             engReq,
  input logic             engDone,
  input logic             engAck,
  input logic             engWrite,
  input logic             engRead,
  input logic [7:0]       engTxByte,
  input logic             engAbort,
  input logic             irq,
  input logic             doneFlag,
  input logic             errFlag,
  input logic             busy,
  input logic [PTR_W-1:0] ptr
);

  // R2: a pending request holds its fields until the engine answers
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engDone && !engAbort) |=> (engReq && $stable(engTxByte) && $stable(engWrite) && $stable(engRead)));

  // R6: an unacknowledged write ends the list
  a_r6_nack_stops: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && engDone && engWrite && !engAck && !engAbort) |=> (!engReq && !busy));

  // R5: done only appears once the sequencer is idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busy);

  // R10 / R11: an abort always leaves the sequencer idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |=> !busy);

  // R7: interrupt needs a raised flag
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneFlag || errFlag));

  // R13: index never runs past the buffer end plus one write step
  a_r13_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(CMD_DEPTH + 1));

endmodule

bind i2cseq_top i2cseq_checker #(.CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .engReq(engReq), .engDone(engDone),
  .engAck(engAck), .engWrite(engWrite), .engRead(engRead),
  .engTxByte(engTxByte), .engAbort(engAbort), .irq(irq),
  .doneFlag(doneFlag), .errFlag(errFlag), .busy(busy), .ptr(ptr)
);

// File: tb/i2cseq_top_bench.sv
module i2cseq_top_bench;

  localparam int ST  = 'h0C;
  localparam int CT  = 'h10;
  localparam int LN  = 'h1C;
  localparam int CMD = 'h30;
  localparam int DAT = 'h80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic engReq, engStart, engStop, engRead, engWrite, engNack, engAbort, irq;
  logic [7:0] engTxByte;
  logic engDone = 1'b0;
  logic engAck = 1'b1;
  logic [7:0] engRxByte = '0;

  always #2 clk = ~clk;  // 250 MHz

  i2cseq_top u_i2cseq_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .engReq(engReq),
    .engStart(engStart), .engStop(engStop), .engRead(engRead),
    .engWrite(engWrite), .engNack(engNack), .engTxByte(engTxByte),
    .engDone(engDone), .engAck(engAck), .engRxByte(engRxByte),
    .engAbort(engAbort), .irq(irq)
  );

  typedef struct {
    logic [4:0] f;     // {start, stop, read, write, nack}
    logic [7:0] tx;
    logic       ack;
    logic [7:0] rx;
  } expReq_t;

  expReq_t expQ[$];
  int nChk = 0;
  int nBad = 0;
  bit summaryDone = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] f, input logic [7:0] tx, input logic ack, input logic [7:0] rx);
    expReq_t e;
    e.f = f; e.tx = tx; e.ack = ack; e.rx = rx;
    expQ.push_back(e);
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'(a); regWData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    regAddr = 8'(a);
    #1;
    d = regRData;
  endtask

  task automatic loadList(input logic [7:0] items[16]);
    for (int i = 0; i < 16; i++) regWrite(CMD + 4 * i, {24'h0, items[i]});
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regRead(ST, s);
      if (s[0] == 1'b0) return;
    end
    nChk++; nBad++;
    $display("FAIL R5: busy never cleared, actual 1 expected 0");
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  // Monitor: stands in for the bit engine and scores each request
  initial begin
    expReq_t e;
    forever begin
      @(negedge clk);
      if (engReq === 1'b1) begin
        e.f = '0; e.tx = '0; e.ack = 1'b1; e.rx = '0;
        nChk++;
        if (expQ.size() == 0) begin
          nBad++;
          $display("FAIL R2: unexpected request actual %b expected none",
                   {engStart, engStop, engRead, engWrite, engNack});
        end else begin
          e = expQ.pop_front();
          nChk--;
          check("R2 request flags", {27'h0, engStart, engStop, engRead, engWrite, engNack}, {27'h0, e.f});
          if (e.f[1]) check("R3 transmit byte", {24'h0, engTxByte}, {24'h0, e.tx});
        end
        repeat (3) @(negedge clk);
        engDone = 1'b1; engAck = e.ack; engRxByte = e.rx;
        @(negedge clk);
        engDone = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] lst[16];

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(ST, v);
    check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 engReq after reset", {31'h0, engReq}, 32'h0);

    regWrite(CT, 32'h0000_1806);

    // Transmit list: address, data, data with STOP (R3, R5, R12, R13)
    lst = '{default: 8'h00};
    lst[0] = 8'h90; lst[1] = 8'hA0; lst[2] = 8'h10; lst[3] = 8'h5A;
    lst[4] = 8'h57; lst[5] = 8'hC3;   // bits 2:0 set and ignored (R2)
    loadList(lst);
    push(5'b10010, 8'hA0, 1'b1, 8'h00);
    push(5'b00010, 8'h5A, 1'b1, 8'h00);
    push(5'b01010, 8'hC3, 1'b1, 8'h00);
    regWrite(LN, 32'h1);
    @(negedge clk);
    regRead(ST, v);
    check("R13 busy and request outstanding", v, 32'h0000_0003);
    waitIdle();
    regRead(ST, v);
    check("R5 R12 R13 write list done", v, 32'h0006_0150);
    check("R7 irq on done", {31'h0, irq}, 32'h1);
    check("R3 queue drained", 32'(expQ.size()), 32'h0);
    regWrite(ST, 32'h0000_0100);
    regRead(ST, v);
    check("R8 done cleared, stop kept", v, 32'h0006_0040);
    check("R8 irq dropped", {31'h0, irq}, 32'h0);

    // Mixed list: address write then reads, last read NACK+STOP (R4)
    lst = '{default: 8'h00};
    lst[0] = 8'h90; lst[1] = 8'hA1;
    lst[2] = 8'h20; lst[3] = 8'h20; lst[4] = 8'h20; lst[5] = 8'h20;
    lst[6] = 8'h68;
    loadList(lst);
    push(5'b10010, 8'hA1, 1'b1, 8'h00);
    push(5'b00100, 8'h00, 1'b1, 8'h11);
    push(5'b00100, 8'h00, 1'b1, 8'h22);
    push(5'b00100, 8'h00, 1'b1, 8'h33);
    push(5'b00100, 8'h00, 1'b1, 8'h44);
    push(5'b01101, 8'h00, 1'b1, 8'h55);
    regWrite(LN, 32'h1);
    waitIdle();
    regRead(ST, v);
    check("R5 R12 read list done", v, 32'h0007_0150);
    regRead(DAT, v);
    check("R4 data word 0 lanes", v, 32'h4433_2211);
    regRead(DAT + 4, v);
    check("R4 data word 1 lane 0", v, 32'h0000_0055);

    // Address not acknowledged (R6)
    lst = '{default: 8'h00};
    lst[0] = 8'h90; lst[1] = 8'hB0; lst[2] = 8'h10; lst[3] = 8'h01; lst[4] = 8'h40;
    loadList(lst);
    push(5'b10010, 8'hB0, 1'b0, 8'h00);
    regWrite(LN, 32'h1);
    waitIdle();
    repeat (10) @(negedge clk);
    regRead(ST, v);
    check("R6 error and nack, no done", v, 32'h0000_0214);
    check("R7 irq on error", {31'h0, irq}, 32'h1);
    check("R6 no further request", 32'(expQ.size()), 32'h0);
    regWrite(ST, 32'h0000_0200);
    regRead(ST, v);
    check("R8 error cleared, nack kept", v, 32'h0000_0004);

    // Interrupt enables (R7)
    regWrite(CT, 32'h0000_0006);
    lst = '{default: 8'h00};
    lst[0] = 8'h40;
    loadList(lst);
    push(5'b01000, 8'h00, 1'b1, 8'h00);
    regWrite(LN, 32'h1);
    waitIdle();
    regRead(ST, v);
    check("R7 done without enable", v, 32'h0001_0140);
    check("R7 irq masked", {31'h0, irq}, 32'h0);
    regWrite(CT, 32'h0000_0806);
    regRead(ST, v);
    check("R7 done with enable", v, 32'h0001_0150);
    check("R7 irq unmasked", {31'h0, irq}, 32'h1);

    // Full buffer, no terminator (R5, R4)
    lst = '{default: 8'h20};
    loadList(lst);
    for (int i = 0; i < 16; i++) push(5'b00100, 8'h00, 1'b1, 8'(8'hA0 + i));
    regWrite(LN, 32'h1);
    waitIdle();
    regRead(ST, v);
    check("R5 stop after entry 15", v, 32'h0010_0110);
    regRead(DAT, v);
    check("R4 full word 0", v, 32'hA3A2_A1A0);
    regRead(DAT + 12, v);
    check("R4 full word 3", v, 32'hAFAE_ADAC);

    // Launch gated by core enable and master mode (R9)
    regWrite(CT, 32'h0000_0002);
    lst = '{default: 8'h00};
    lst[0] = 8'h40;
    loadList(lst);
    regWrite(LN, 32'h1);
    repeat (10) @(negedge clk);
    regRead(ST, v);
    check("R9 launch ignored, flags untouched", v, 32'h0010_0100);
    check("R9 no request", {31'h0, engReq}, 32'h0);

    // Halt during a request (R10)
    regWrite(CT, 32'h0000_1806);
    lst = '{default: 8'h00};
    lst[0] = 8'h20; lst[1] = 8'h20; lst[2] = 8'h20;
    loadList(lst);
    push(5'b00100, 8'h00, 1'b1, 8'h77);
    regWrite(LN, 32'h1);
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'(LN); regWData = 32'h0;
    #1;
    check("R10 abort pulse on halt", {31'h0, engAbort}, 32'h1);
    @(negedge clk);
    regWr = 1'b0;
    repeat (10) @(negedge clk);
    regRead(ST, v);
    check("R10 idle, no done", v, 32'h0000_0000);
    check("R10 single request only", 32'(expQ.size()), 32'h0);

    // Soft reset (R11)
    lst = '{default: 8'h00};
    lst[0] = 8'h40;
    loadList(lst);
    push(5'b01000, 8'h00, 1'b1, 8'h00);
    regWrite(LN, 32'h1);
    waitIdle();
    regRead(ST, v);
    check("R11 pre-reset flags", v, 32'h0001_0150);
    regWrite(CT, 32'h0000_1807);
    regRead(CT, v);
    check("R11 reset bit visible one cycle", v, 32'h0000_1807);
    check("R11 abort pulse on reset", {31'h0, engAbort}, 32'h1);
    @(negedge clk);
    regRead(CT, v);
    check("R11 reset bit self-cleared", v, 32'h0000_1806);
    regRead(ST, v);
    check("R11 status and index cleared", v, 32'h0000_0000);
    check("R11 abort released", {31'h0, engAbort}, 32'h0);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule